// File: doc/BRIEF.md
# Symbol-Rate DPSK Demodulator with Coherent Switchover

This block turns one phase sample per symbol, taken at the correlation peak, into a data bit. While the carrier loop is still acquiring, it decides each bit differentially. It subtracts the raw phase of the previous symbol from the raw phase of the current one, and the difference picks the bit. Once a lock input reports that the carrier loop is tracking, the block moves to coherent decisions. In that mode it reads the NCO-corrected phase directly and no longer uses the symbol-to-symbol difference.

For every symbol the block also works out a signed phase error. This is the decision phase folded onto the nearer of the two ideal points, 0 or half a turn. The errors are collected over windows of 16 symbols. At the end of each window the block reports the mean error as a frequency estimate for the loop filter, and the variance of the error as a signal-quality figure. The loop filter and the NCO sit outside this block.

Top module: `dpsk_demod`

## Requirements
- R1: After reset, and after any later reset, `bit_valid` and `stat_valid` are 0, `coherent` is 0 (differential mode), `bit_out` is 0, `err_avg` and `err_var` are 0, the stored previous phase is 0 and the window count is empty.
- R2: `bit_valid` is 1 in the cycle after each cycle in which `sym_strobe` is 1. It is 0 in the cycle after every cycle in which `sym_strobe` is 0.
- R3: In differential mode the decision phase is (`phase_raw` minus the `phase_raw` of the previous strobe) mod 256. The bit is 1 when this value lies in [64,191] and 0 otherwise. The previous phase is captured on every strobe, in either mode.
- R4: In coherent mode the decision phase is `phase_corr`, and the bit is 1 when it lies in [64,191].
- R5: `lock` is sampled only on a strobe, and the mode it selects applies from the next strobe onward. The decision on the strobe that samples a change still uses the old mode. `coherent` shows the new mode from the cycle after that strobe. Dropping `lock` returns the block to differential mode by the same rule.
- R6: The per-symbol error is the decision phase taken as an 8-bit two's-complement value when the bit is 0, and the decision phase minus 128 taken the same way when the bit is 1. This keeps the error within [-64,63].
- R7: On every 16th strobe after reset, `stat_valid` pulses in the same cycle as `bit_valid`. At that point `err_avg` is the sum of the window's 16 errors shifted right arithmetically by 4 bits, which is the floor of the sum divided by 16. The next window then starts empty.
- R8: `err_var` is the window's sum of squared errors shifted right by 4, minus the square of `err_avg`, clamped at 0. It updates together with `err_avg`.
- R9: While `sym_strobe` is 0, changes on `phase_raw`, `phase_corr` and `lock` alter no output and no stored state: the previous phase, the mode and the window sums all stay as they are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sym_strobe | input | 1 | One-cycle pulse at each correlation peak |
| phase_raw | input | 8 | Uncorrected phase sample, unsigned, one full turn |
| phase_corr | input | 8 | NCO-corrected phase sample, unsigned, one full turn |
| lock | input | 1 | Carrier loop locked, sampled on a strobe |
| bit_out | output | 1 | Decided bit, held between strobes |
| bit_valid | output | 1 | One-cycle pulse when `bit_out` is new |
| coherent | output | 1 | 1 when the block is in coherent mode |
| err_avg | output | 8 | Signed mean phase error of the last window |
| err_var | output | 15 | Phase-error variance of the last window |
| stat_valid | output | 1 | One-cycle pulse when `err_avg` and `err_var` are new |

## Verification
The assertions take for granted that the strobe is a pulse sent once per symbol, that it can fall on any cycle including back to back, and that `lock` and the phase inputs only matter on strobe cycles. Nothing about them is assumed between strobes. The stimulus drives every input at the falling edge. It raises the strobe for single cycles and also back to back, and it moves the phase inputs and `lock` to unrelated values during idle gaps so the hold behaviour is tested. The phase values sit on the decision boundaries 63, 64, 191 and 192 and on the wrap-around at 0 and 255. One window is built so that its variance goes below zero and has to be clamped.

// File: rtl/dpsk_pkg.sv
package dpsk_pkg;
  typedef enum logic {
    MODE_DIFF = 1'b0,
    MODE_COH  = 1'b1
  } demod_mode_e;
endpackage

// File: rtl/dpsk_decider.sv
module dpsk_decider
  import dpsk_pkg::*;
#(
  parameter int PH_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sym_strobe,
  input  logic [PH_W-1:0]        phase_raw,
  input  logic [PH_W-1:0]        phase_corr,
  input  logic                   lock,
  output logic                   bit_q,
  output logic                   bit_vld_q,
  output logic                   coh_q,
  output logic signed [PH_W-1:0] err_now
);
  localparam logic [PH_W-1:0] HALF_TURN = {1'b1, {(PH_W-1){1'b0}}};

  logic [PH_W-1:0] prev_q, prev_d;
  demod_mode_e     mode_q, mode_d;
  logic            bit_d, vld_d;
  logic [PH_W-1:0] diff_ph, dec_ph, folded;
  logic            dec_bit;

  // decision path
  always_comb begin
    diff_ph = phase_raw - prev_q;
    dec_ph  = (mode_q == MODE_COH) ? phase_corr : diff_ph;
    dec_bit = dec_ph[PH_W-1] ^ dec_ph[PH_W-2];
    folded  = dec_bit ? (dec_ph - HALF_TURN) : dec_ph;
    err_now = signed'(folded);
  end

  // next state, written out with the strobe as enable
  always_comb begin
    prev_d = prev_q;
    mode_d = mode_q;
    bit_d  = bit_q;
    vld_d  = sym_strobe;
    if (sym_strobe) begin
      prev_d = phase_raw;
      mode_d = lock ? MODE_COH : MODE_DIFF;
      bit_d  = dec_bit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q    <= '0;
      mode_q    <= MODE_DIFF;
      bit_q     <= 1'b0;
      bit_vld_q <= 1'b0;
    end else begin
      prev_q    <= prev_d;
      mode_q    <= mode_d;
      bit_q     <= bit_d;
      bit_vld_q <= vld_d;
    end
  end

  assign coh_q = (mode_q == MODE_COH);

  assert_strobe_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sym_strobe |=> bit_vld_q);
  assert_idle_no_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_strobe |=> !bit_vld_q);
  assert_mode_follows_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sym_strobe |=> (coh_q == $past(lock)));
  assert_mode_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_strobe |=> $stable(coh_q));
  assert_bit_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_strobe |=> $stable(bit_q));
endmodule

// File: rtl/dpsk_err_stats.sv
module dpsk_err_stats #(
  parameter int PH_W     = 8,
  parameter int WIN_LOG2 = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     err_vld,
  input  logic signed [PH_W-1:0]   err_in,
  output logic                     stat_vld_q,
  output logic signed [PH_W-1:0]   avg_q,
  output logic [2*PH_W-2:0]        var_q
);
  localparam int SUM_W = PH_W + WIN_LOG2;
  localparam int SQ_W  = 2*PH_W + WIN_LOG2;
  localparam int VAR_W = 2*PH_W - 1;
  localparam int PAD_W = SQ_W + 1 - 2*PH_W;
  localparam logic [VAR_W-1:0] VAR_MAX = VAR_W'(1) << (2*PH_W - 4);

  logic [WIN_LOG2-1:0]      cnt_q, cnt_d;
  logic signed [SUM_W-1:0]  sum_q, sum_d, sum_tot, avg_full;
  logic [SQ_W-1:0]          sq_q, sq_d, sq_tot, mean_sq;
  logic signed [2*PH_W-1:0] err_sq, avg_sq;
  logic signed [PH_W-1:0]   avg_n, avg_d;
  logic signed [SQ_W:0]     var_full;
  logic [VAR_W-1:0]         var_n, var_d;
  logic                     win_end, vld_d;

  always_comb begin
    win_end  = &cnt_q;
    err_sq   = err_in * err_in;
    sum_tot  = sum_q + SUM_W'(err_in);
    sq_tot   = sq_q + SQ_W'(unsigned'(err_sq));
    avg_full = sum_tot >>> WIN_LOG2;
    avg_n    = avg_full[PH_W-1:0];
    mean_sq  = sq_tot >> WIN_LOG2;
    avg_sq   = avg_n * avg_n;
    var_full = signed'({1'b0, mean_sq}) - signed'({{PAD_W{1'b0}}, unsigned'(avg_sq)});
    var_n    = (var_full < 0) ? '0 : var_full[VAR_W-1:0];
  end

  always_comb begin
    cnt_d = cnt_q;
    sum_d = sum_q;
    sq_d  = sq_q;
    avg_d = avg_q;
    var_d = var_q;
    vld_d = 1'b0;
    if (err_vld) begin
      cnt_d = cnt_q + 1'b1;
      if (win_end) begin
        sum_d = '0;
        sq_d  = '0;
        avg_d = avg_n;
        var_d = var_n;
        vld_d = 1'b1;
      end else begin
        sum_d = sum_tot;
        sq_d  = sq_tot;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      sum_q      <= '0;
      sq_q       <= '0;
      avg_q      <= '0;
      var_q      <= '0;
      stat_vld_q <= 1'b0;
    end else begin
      cnt_q      <= cnt_d;
      sum_q      <= sum_d;
      sq_q       <= sq_d;
      avg_q      <= avg_d;
      var_q      <= var_d;
      stat_vld_q <= vld_d;
    end
  end

  assert_stat_needs_symbol_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stat_vld_q |-> $past(err_vld));
  assert_stat_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stat_vld_q |=> !stat_vld_q);
  assert_stats_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_vld_q |-> ($stable(avg_q) && $stable(var_q)));
  assert_var_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stat_vld_q |-> (var_q <= VAR_MAX));
endmodule

// File: rtl/dpsk_demod.sv
module dpsk_demod #(
  parameter int PH_W     = 8,
  parameter int WIN_LOG2 = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sym_strobe,
  input  logic [PH_W-1:0]        phase_raw,
  input  logic [PH_W-1:0]        phase_corr,
  input  logic                   lock,
  output logic                   bit_out,
  output logic                   bit_valid,
  output logic                   coherent,
  output logic signed [PH_W-1:0] err_avg,
  output logic [2*PH_W-2:0]      err_var,
  output logic                   stat_valid
);
  logic signed [PH_W-1:0] sym_err;

  dpsk_decider #(.PH_W(PH_W)) i_decider (
    .clk        (clk),
    .rst_n      (rst_n),
    .sym_strobe (sym_strobe),
    .phase_raw  (phase_raw),
    .phase_corr (phase_corr),
    .lock       (lock),
    .bit_q      (bit_out),
    .bit_vld_q  (bit_valid),
    .coh_q      (coherent),
    .err_now    (sym_err)
  );

  dpsk_err_stats #(.PH_W(PH_W), .WIN_LOG2(WIN_LOG2)) i_stats (
    .clk        (clk),
    .rst_n      (rst_n),
    .err_vld    (sym_strobe),
    .err_in     (sym_err),
    .stat_vld_q (stat_valid),
    .avg_q      (err_avg),
    .var_q      (err_var)
  );

  assert_stat_with_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |-> bit_valid);
endmodule

// File: tb/test_dpsk_demod.sv
module test_dpsk_demod;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        sym_strobe;
  logic [7:0]  phase_raw, phase_corr;
  logic        lock;
  logic        bit_out, bit_valid, coherent, stat_valid;
  logic signed [7:0] err_avg;
  logic [14:0] err_var;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // model state
  int m_prev, m_cnt, m_sum, m_sq;
  bit m_coh, m_bit;

  always #4 clk = ~clk;

  dpsk_demod i_dpsk_demod (
    .clk(clk), .rst_n(rst_n), .sym_strobe(sym_strobe),
    .phase_raw(phase_raw), .phase_corr(phase_corr), .lock(lock),
    .bit_out(bit_out), .bit_valid(bit_valid), .coherent(coherent),
    .err_avg(err_avg), .err_var(err_var), .stat_valid(stat_valid)
  );

  // {phase_raw, phase_corr, lock}
  localparam logic [16:0] VEC [24] = '{
    {8'd10,  8'd0,   1'b0}, {8'd74,  8'd0,   1'b0}, {8'd137, 8'd0,   1'b0},
    {8'd72,  8'd0,   1'b0}, {8'd8,   8'd0,   1'b0}, {8'd136, 8'd0,   1'b0},
    {8'd136, 8'd0,   1'b0}, {8'd200, 8'd0,   1'b0}, {8'd30,  8'd99,  1'b1},
    {8'd5,   8'd63,  1'b1}, {8'd77,  8'd64,  1'b1}, {8'd90,  8'd191, 1'b1},
    {8'd91,  8'd192, 1'b1}, {8'd0,   8'd255, 1'b1}, {8'd3,   8'd128, 1'b1},
    {8'd250, 8'd1,   1'b1}, {8'd17,  8'd127, 1'b1}, {8'd40,  8'd129, 1'b0},
    {8'd104, 8'd33,  1'b0}, {8'd100, 8'd200, 1'b0}, {8'd228, 8'd7,   1'b0},
    {8'd36,  8'd70,  1'b0}, {8'd164, 8'd190, 1'b0}, {8'd160, 8'd12,  1'b0}
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_prev = 0; m_cnt = 0; m_sum = 0; m_sq = 0; m_coh = 0; m_bit = 0;
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0; sym_strobe = 1'b0; phase_raw = 8'd0; phase_corr = 8'd0; lock = 1'b0;
    model_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 bit_valid", bit_valid, 0);
    chk("R1 stat_valid", stat_valid, 0);
    chk("R1 coherent", coherent, 0);
    chk("R1 bit_out", bit_out, 0);
    chk("R1 err_avg", err_avg, 0);
    chk("R1 err_var", err_var, 0);
  endtask

  // one strobe from a falling edge, checked at the next falling edge
  task automatic strobe(input int ph, input int cp, input bit lk);
    int dp, err, avg, v;
    bit last;
    sym_strobe = 1'b1; phase_raw = 8'(ph); phase_corr = 8'(cp); lock = lk;
    dp = m_coh ? cp : ((ph - m_prev) & 255);
    m_bit = (dp >= 64 && dp <= 191);
    if (m_bit) err = dp - 128;
    else err = (dp >= 128) ? dp - 256 : dp;
    m_prev = ph;
    m_coh = lk;
    m_sum += err;
    m_sq += err * err;
    m_cnt++;
    last = (m_cnt == 16);
    @(posedge clk);
    @(negedge clk);
    sym_strobe = 1'b0;
    chk("R2 bit_valid after strobe", bit_valid, 1);
    chk(m_coh == lk && dp == cp && m_cnt > 0 ? "R3/R4 bit" : "R3 bit", bit_out, m_bit);
    chk("R5 coherent", coherent, lk);
    chk("R7 stat_valid", stat_valid, last);
    if (last) begin
      avg = (m_sum >= 0) ? m_sum / 16 : -((-m_sum + 15) / 16);
      v = (m_sq / 16) - avg * avg;
      if (v < 0) v = 0;
      chk("R6 R7 err_avg", err_avg, avg);
      chk("R8 err_var", err_var, v);
      m_cnt = 0; m_sum = 0; m_sq = 0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    sym_strobe = 1'b0; phase_raw = '0; phase_corr = '0; lock = 1'b0;
    apply_reset();

    // vector table: differential boundaries, switch (R5), coherent (R4), back
    for (int i = 0; i < 24; i++)
      strobe(int'(VEC[i][16:9]), int'(VEC[i][8:1]), VEC[i][0]);

    // R2 no pulse when idle, R9 inputs ignored while idle
    sym_strobe = 1'b0;
    phase_raw = 8'd33; phase_corr = 8'd100; lock = 1'b1;
    @(negedge clk);
    chk("R2 no bit_valid idle", bit_valid, 0);
    phase_raw = 8'd201; lock = 1'b0;
    @(negedge clk);
    lock = 1'b1;
    @(negedge clk);
    chk("R9 bit_out held", bit_out, m_bit);
    chk("R9 coherent held", coherent, 0);
    chk("R9 stat_valid idle", stat_valid, 0);
    // previous phase still 160: 224 gives difference 64, so bit 1 (R3, R9)
    strobe(224, 5, 1'b0);
    chk("R9 previous phase kept", bit_out, 1);

    // R5 lock toggling, back to back strobes, window ends at 32
    strobe(224, 9, 1'b1);
    strobe(100, 70, 1'b1);
    strobe(101, 250, 1'b0);
    strobe(40, 130, 1'b0);
    strobe(170, 66, 1'b1);
    strobe(170, 180, 1'b1);
    strobe(60, 3, 1'b1);

    // R1 second reset, then a window whose variance goes negative (R8 clamp)
    apply_reset();
    for (int i = 0; i < 16; i++)
      strobe((i >= 7) ? 255 : 0, 0, 1'b0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule